// File: doc/BRIEF.md
# Video Memory Dirty-Page Tracker

This block keeps one dirty flag for every 4096-byte page of a 4 MB frame-buffer memory. A scanout engine uses it to decide, line by line, whether a display line must be redrawn or can be skipped. Every write to video memory is reported on the write-monitor port, and the flag of the page it lands in is set. A write comes either as a byte address, for chain-4 and odd/even mappings, or as a word address from latched planar mode. A word address is multiplied by four before its page is chosen.

The scanout side asks one question per line. It gives the line's start byte address, its width in bytes and a full-redraw flag. One cycle later the block answers whether the line must be drawn. After a frame, the scanout side issues a range clear for the lowest and highest page it consumed. That clear drops every flag in that inclusive range, except a flag that a write sets in the same cycle. The memory itself lives elsewhere.

Top module: `vram_dirty_tracker`

## Requirements
- R1: After reset every page flag is clean, `resp_valid` is low, and a query with `q_full` low returns clean.
- R2: With `wr_word_addr` low, a write sets the flag of page `wr_addr[21:12]`.
- R3: With `wr_word_addr` high, the byte address is `wr_addr` shifted left by 2 and truncated to 22 bits. The page set is therefore `wr_addr[19:10]`, and `wr_addr[21:20]` has no effect.
- R4: `resp_valid` is high in exactly the cycle after a cycle with `q_valid` high.
- R5: The answer is the OR of four terms: `q_full`, the flag of page P0, the flag of page P1, and the extra page of R6. P0 is the page of `q_start`. P1 is the page of the last byte, computed as (`q_start` + W − 1) mod 4 MB. W is `q_width`, and a width of 0 counts as 1.
- R6: When (P1 − P0) mod 1024 is greater than 1, the flag of page (P0 + 1) mod 1024 is also ORed in. No other page between P0 and P1 is examined.
- R7: A clear with `clr_valid` high resets every flag from page `clr_lo` to page `clr_hi` inclusive. It touches no flag outside that range. When `clr_lo` is greater than `clr_hi`, the clear changes nothing.
- R8: If a write sets a page in the same cycle that a clear covers it, the page ends dirty.
- R9: A query sees the flags as they were before the clock edge that samples it. A write or clear in that same cycle is not visible in that query's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A video-memory write occurred this cycle |
| wr_word_addr | input | 1 | 1: `wr_addr` is a planar word address; 0: byte address |
| wr_addr | input | 22 | Write address |
| q_valid | input | 1 | Line query this cycle |
| q_start | input | 22 | Line start byte address |
| q_width | input | 16 | Line width in bytes (0 treated as 1) |
| q_full | input | 1 | Force the line to be reported dirty |
| clr_valid | input | 1 | Range clear this cycle |
| clr_lo | input | 10 | First page of the clear range |
| clr_hi | input | 10 | Last page of the clear range |
| resp_valid | output | 1 | Query answer valid |
| resp_dirty | output | 1 | Line must be redrawn |

## Verification
The bench targets lines that end exactly on a page boundary or one byte past it. A design that dropped the minus-one in the last-byte arithmetic would report the neighbouring page. Lines that span three or four pages are tested with only an inner page dirty. A design that scanned all of P0..P1, or skipped the extra page, answers the wrong way. The bench also covers a line that wraps from the top page to page 0, planar word writes with set upper address bits, inverted clear ranges, and a write coinciding with a clear or a query. These catch a clear that beats the mark, an inverted range treated as a wraparound, and a query that sees a same-cycle write.

// File: rtl/vdt_pkg.sv
package vdt_pkg;
  localparam int VDT_ADDR_W     = 22;  // 4 MB of video memory
  localparam int VDT_PAGE_SHIFT = 12;  // 4096-byte pages
  localparam int VDT_LINE_W     = 16;  // line width field
  localparam int VDT_WORD_SHIFT = 2;   // planar word to byte scaling
endpackage

// File: rtl/vdt_mark_decode.sv
module vdt_mark_decode #(
  parameter int ADDR_W     = vdt_pkg::VDT_ADDR_W,
  parameter int PAGE_SHIFT = vdt_pkg::VDT_PAGE_SHIFT,
  parameter int WORD_SHIFT = vdt_pkg::VDT_WORD_SHIFT,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic              wr_valid,
  input  logic              wr_word_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mark_en,
  output logic [PAGE_W-1:0] mark_page
);
  // Byte address of the write, scaled for planar word addresses.
  function automatic logic [ADDR_W-1:0] to_byte(input logic word, input logic [ADDR_W-1:0] a);
    return word ? (a << WORD_SHIFT) : a;
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] b);
    return b[ADDR_W-1:PAGE_SHIFT];
  endfunction

  logic [ADDR_W-1:0] byte_addr;
  assign byte_addr = to_byte(wr_word_addr, wr_addr);
  assign mark_en   = wr_valid;
  assign mark_page = page_of(byte_addr);
endmodule

// File: rtl/vdt_page_bits.sv
module vdt_page_bits #(
  parameter int PAGE_W  = vdt_pkg::VDT_ADDR_W - vdt_pkg::VDT_PAGE_SHIFT,
  localparam int NPAGES = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_en,
  input  logic [PAGE_W-1:0] mark_page,
  input  logic              clr_en,
  input  logic [PAGE_W-1:0] clr_lo,
  input  logic [PAGE_W-1:0] clr_hi,
  output logic [NPAGES-1:0] dirty_q
);
  function automatic logic in_range(input logic [PAGE_W-1:0] p, input logic [PAGE_W-1:0] lo,
                                    input logic [PAGE_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  for (genvar i = 0; i < NPAGES; i++) begin : g_page
    logic hit_set, hit_clr;
    assign hit_set = mark_en && (mark_page == PAGE_W'(i));
    assign hit_clr = clr_en && in_range(PAGE_W'(i), clr_lo, clr_hi);
    always_ff @(posedge clk) begin
      if (!rst_n)       dirty_q[i] <= 1'b0;
      else if (hit_set) dirty_q[i] <= 1'b1;  // mark outranks clear
      else if (hit_clr) dirty_q[i] <= 1'b0;
    end
  end

  assert_mark_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |=> dirty_q[$past(mark_page)]);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !mark_en && (clr_lo <= clr_hi)) |=> !dirty_q[$past(clr_lo)]);

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_en && !clr_en) |=> $stable(dirty_q));
endmodule

// File: rtl/vdt_line_probe.sv
module vdt_line_probe #(
  parameter int ADDR_W     = vdt_pkg::VDT_ADDR_W,
  parameter int PAGE_SHIFT = vdt_pkg::VDT_PAGE_SHIFT,
  parameter int LINE_W     = vdt_pkg::VDT_LINE_W,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int NPAGES    = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_start,
  input  logic [LINE_W-1:0] q_width,
  input  logic              q_full,
  input  logic [NPAGES-1:0] dirty_q,
  output logic              resp_valid,
  output logic              resp_dirty
);
  function automatic logic [ADDR_W-1:0] last_byte(input logic [ADDR_W-1:0] s,
                                                  input logic [LINE_W-1:0] w);
    logic [LINE_W-1:0] w_eff;
    w_eff = (w == '0) ? LINE_W'(1) : w;
    return s + ADDR_W'(w_eff) - ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] end_addr;
  logic [PAGE_W-1:0] pg_first, pg_last, pg_next, pg_gap;
  logic              wide_line, hit;

  assign end_addr  = last_byte(q_start, q_width);
  assign pg_first  = q_start[ADDR_W-1:PAGE_SHIFT];
  assign pg_last   = end_addr[ADDR_W-1:PAGE_SHIFT];
  assign pg_next   = pg_first + PAGE_W'(1);
  assign pg_gap    = pg_last - pg_first;
  assign wide_line = pg_gap > PAGE_W'(1);
  assign hit       = q_full | dirty_q[pg_first] | dirty_q[pg_last] |
                     (wide_line & dirty_q[pg_next]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_dirty <= 1'b0;
    end else begin
      resp_valid <= q_valid;
      resp_dirty <= q_valid & hit;
    end
  end

  assert_resp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> resp_valid);
  assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !resp_valid);
  assert_full_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_full) |=> resp_dirty);
  assert_first_page_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && dirty_q[pg_first]) |=> resp_dirty);
endmodule

// File: rtl/vram_dirty_tracker.sv
module vram_dirty_tracker #(
  parameter int ADDR_W     = vdt_pkg::VDT_ADDR_W,
  parameter int PAGE_SHIFT = vdt_pkg::VDT_PAGE_SHIFT,
  parameter int LINE_W     = vdt_pkg::VDT_LINE_W,
  parameter int WORD_SHIFT = vdt_pkg::VDT_WORD_SHIFT,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int NPAGES    = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_word_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_start,
  input  logic [LINE_W-1:0] q_width,
  input  logic              q_full,
  input  logic              clr_valid,
  input  logic [PAGE_W-1:0] clr_lo,
  input  logic [PAGE_W-1:0] clr_hi,
  output logic              resp_valid,
  output logic              resp_dirty
);
  logic              mark_en;
  logic [PAGE_W-1:0] mark_page;
  logic [NPAGES-1:0] dirty_q;

  vdt_mark_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WORD_SHIFT(WORD_SHIFT)) u_mark (
    .wr_valid(wr_valid), .wr_word_addr(wr_word_addr), .wr_addr(wr_addr),
    .mark_en(mark_en), .mark_page(mark_page)
  );

  vdt_page_bits #(.PAGE_W(PAGE_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .mark_page(mark_page),
    .clr_en(clr_valid), .clr_lo(clr_lo), .clr_hi(clr_hi), .dirty_q(dirty_q)
  );

  vdt_line_probe #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LINE_W(LINE_W)) u_probe (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_start(q_start), .q_width(q_width),
    .q_full(q_full), .dirty_q(dirty_q), .resp_valid(resp_valid), .resp_dirty(resp_dirty)
  );

  // R3: a planar word write never marks a page above the scaled range top.
  assert_word_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word_addr) |-> (mark_page[PAGE_W-1:PAGE_W-WORD_SHIFT] ==
                                    wr_addr[ADDR_W-WORD_SHIFT-1:ADDR_W-2*WORD_SHIFT]));
endmodule

// File: tb/vram_dirty_tracker_tb.sv
module vram_dirty_tracker_tb;
  localparam int MEM = 1 << 22;
  localparam int NP  = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_word_addr = 0, q_valid = 0, q_full = 0, clr_valid = 0;
  logic [21:0] wr_addr = '0, q_start = '0;
  logic [15:0] q_width = '0;
  logic [9:0]  clr_lo = '0, clr_hi = '0;
  logic resp_valid, resp_dirty;

  int checks = 0, errors = 0;
  bit ref_pg [NP];

  always #4 clk = ~clk;  // 125 MHz

  vram_dirty_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word_addr(wr_word_addr),
    .wr_addr(wr_addr), .q_valid(q_valid), .q_start(q_start), .q_width(q_width),
    .q_full(q_full), .clr_valid(clr_valid), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .resp_valid(resp_valid), .resp_dirty(resp_dirty)
  );

  function automatic bit model_query(int s, int w, bit full);
    int we, last, p0, p1, gap;
    we   = (w == 0) ? 1 : w;
    last = (s + we - 1) % MEM;
    p0   = s / 4096;
    p1   = last / 4096;
    gap  = (p1 - p0 + NP) % NP;
    return full | ref_pg[p0] | ref_pg[p1] | ((gap > 1) & ref_pg[(p0 + 1) % NP]);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: expected from pre-edge model state, then model update, then compare.
  task automatic step(string tag);
    bit ev, ed;
    int pg;
    ev = q_valid;
    ed = q_valid ? model_query(int'(q_start), int'(q_width), q_full) : 1'b0;
    if (clr_valid)
      for (int p = int'(clr_lo); p <= int'(clr_hi); p++) ref_pg[p] = 1'b0;
    if (wr_valid) begin
      pg = wr_word_addr ? ((int'(wr_addr) * 4) % MEM) / 4096 : int'(wr_addr) / 4096;
      ref_pg[pg] = 1'b1;
    end
    @(posedge clk); #1;
    check(tag, "resp_valid", int'(resp_valid), int'(ev));
    if (ev) check(tag, "resp_dirty", int'(resp_dirty), int'(ed));
    @(negedge clk);
    wr_valid = 0; wr_word_addr = 0; q_valid = 0; q_full = 0; clr_valid = 0;
  endtask

  task automatic wr(int a, bit word);
    wr_valid = 1; wr_word_addr = word; wr_addr = 22'(a);
  endtask
  task automatic qry(int s, int w, bit full);
    q_valid = 1; q_start = 22'(s); q_width = 16'(w); q_full = full;
  endtask
  task automatic clr(int lo, int hi);
    clr_valid = 1; clr_lo = 10'(lo); clr_hi = 10'(hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) ref_pg[p] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    step("R1");
    qry(0, 1, 0); step("R1");
    qry(22'h3FF000, 4096, 0); step("R1");
    qry(0, 1, 1); step("R5");
    // R2: byte-address write, page boundaries
    wr(22'h003456, 0); step("R2");
    qry(22'h3000, 16, 0); step("R2");
    qry(22'h2000, 22'h1000, 0); step("R5");   // ends at 0x2FFF, page 2
    qry(22'h2000, 22'h1001, 0); step("R5");   // reaches 0x3000, page 3
    qry(22'h2FFF, 0, 0); step("R5");          // width 0 counts as 1 byte
    // R3: word address scaled, upper bits dropped
    wr(22'h321400, 1); step("R3");
    qry(22'h85000, 1, 0); step("R3");
    qry(22'h21000, 1, 0); step("R3");
    // R6: extra page only when gap > 1
    wr(22'hB000, 0); step("R6");
    qry(22'hA800, 22'h1900, 0); step("R6");   // pages 10..12, inner 11 dirty
    qry(22'h9F00, 22'h200, 0); step("R6");    // pages 9,10 only
    wr(22'h32000, 0); step("R6");
    qry(22'h30000, 22'h4000, 0); step("R6");  // 48..51, page 50 not examined
    // R5: wrap from top page to page 0
    wr(22'h000010, 0); step("R5");
    qry(22'h3FF800, 22'h1000, 0); step("R5");
    // R7: range clear
    clr(3, 11); step("R7");
    qry(22'h3000, 1, 0); step("R7");
    qry(22'hB000, 1, 0); step("R7");
    qry(22'h32000, 1, 0); step("R7");
    qry(22'h0, 1, 0); step("R7");
    clr(200, 100); step("R7");                // inverted: no effect
    qry(22'h85000, 1, 0); step("R7");
    // R8: mark beats clear
    wr(22'h7000, 0); clr(0, 1023); step("R8");
    qry(22'h7000, 1, 0); step("R8");
    qry(22'h32000, 1, 0); step("R8");
    // R9: same-cycle write invisible to query
    wr(22'h14000, 0); qry(22'h14000, 1, 0); step("R9");
    qry(22'h14000, 1, 0); step("R9");
    // R4/R5/R6: mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 2) == 0) wr(int'($urandom_range(0, 22'h3FFFFF)) & 22'h03FFFF |
                                        ($urandom_range(0, 1) ? 22'h3C0000 : 0), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 0) qry($urandom_range(0, 22'h3FFFFF) & 22'h03FFFF,
                                         $urandom_range(0, 22'h5000), ($urandom_range(0, 15) == 0));
      if ($urandom_range(0, 19) == 0) begin
        int a = $urandom_range(0, 70);
        clr(a, a + $urandom_range(0, 20) - 5);
      end
      step("R4");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule